// File: doc/BRIEF.md
# Compressed Instruction Expander with Reserved-Encoding Trap

This block sits between instruction fetch and decode. Each cycle it may accept one 32-bit fetch word. When the low two bits of the word are not `11`, only the low halfword is a 16-bit compressed parcel. The block rewrites that parcel into the equivalent 64-bit base-ISA instruction one cycle later. Words whose low two bits are `11` are already full-length instructions and pass through unchanged.

Every reserved or constrained compressed encoding is caught and reported on a separate illegal flag. This covers destination or source registers that must be nonzero and immediates that must be nonzero. The pipeline turns a flagged instruction into an illegal-instruction trap and never issues it. For a flagged parcel the expansion is forced to zero, so it can never turn into a memory access. The trap value output carries only the 16 parcel bits. The halfword that happens to follow in the fetch word never leaks into it, which matters when a jump lands on a 2-byte boundary.

Top module: `rvc_expander`

## Requirements
- R1: A word with bits [1:0] = 11 is reproduced unchanged on `expanded_o`, with `illegal_o` = 0 and `tval_o` = 0.
- R2: The outputs appear on the clock edge after the input is accepted. `valid_o` equals `valid_i` delayed by one cycle. Reset drives `valid_o` and `illegal_o` to 0.
- R3: A stack-pointer word load (quadrant 2, funct3 010) or doubleword load (funct3 011) with destination field [11:7] = 0 is flagged illegal. Parcel 0x401A is such a load (x0, offset 132 from sp) and must be flagged.
- R4: A legal stack-pointer word load forms its offset as: bit 5 from bit 12, bits 4:2 from bits 6:4, bits 7:6 from bits 3:2, zero-extended. For example, 0x409A expands to 0x08412083.
- R5: A register jump (quadrant 2, funct3 100, bit 12 = 0, bits [6:2] = 0) with source field [11:7] = 0, and a 32-bit add-immediate (quadrant 1, funct3 001) with destination 0, are illegal.
- R6: These forms are illegal when their immediate is zero: the upper-immediate load (quadrant 1, funct3 011, destination not 2), the stack adjust (same slot, destination 2) and the stack-based address form (quadrant 0, funct3 000). The all-zero parcel 0x0000 is therefore illegal.
- R7: Reserved slots are illegal: quadrant 0 funct3 100, and the quadrant 1 register-register group (bits [15:13] = 100, [11:10] = 11) with bit 12 = 1 and bits [6:5] = 10 or 11.
- R8: When `illegal_o` is 1, `expanded_o` is 0 and `tval_o` holds the parcel in bits [15:0] with bits [31:16] zero. A legal result has `tval_o` = 0.
- R9: For a compressed parcel the upper halfword of the fetch word has no effect on any output. For example, 0x8931401A yields `tval_o` = 0x0000401A.
- R10: Every other compressed encoding in quadrants 0 to 2 expands to its 64-bit base equivalent. Hint encodings are legal, and 0x9002 expands to the breakpoint 0x00100073.
- R11: In a cycle with `valid_o` = 0, `illegal_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Fetch word present this cycle |
| instr_i | input | 32 | Fetch word; parcel in [15:0] when compressed |
| valid_o | output | 1 | Result present |
| expanded_o | output | 32 | Base-ISA instruction, zero when illegal |
| illegal_o | output | 1 | Reserved or constrained encoding seen |
| tval_o | output | 32 | Zero-extended parcel when illegal, else zero |

## Verification
The bench aims at the zero-register loads (0x401A and its doubleword form) and at zero-source register jumps, zero-immediate stack adjusts, zero-immediate upper loads and the reserved arithmetic slots. A design that missed any of these would expand the parcel into a real load, jump or add instead of trapping. It also drives compressed parcels with junk in the upper halfword. A design that copied the whole word into the trap value, or decoded across the boundary, would report values such as 0x8931401A. Thousands of random words are compared against a behavioural model, which exposes any offset bit that lands in the wrong position.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int unsigned ILEN     = 32;
  localparam int unsigned PARCEL_W = 16;
  localparam int unsigned RIDX_W   = 5;
  localparam int unsigned IMM_W    = 12;
  localparam int unsigned UIMM_W   = 20;
  localparam int unsigned JIMM_W   = 21;
  localparam int unsigned BIMM_W   = 13;

  typedef logic [6:0]        opc_t;
  typedef logic [RIDX_W-1:0] ridx_t;
  typedef logic [ILEN-1:0]   word_t;

  localparam opc_t OPC_LOAD    = 7'b0000011;
  localparam opc_t OPC_LOADFP  = 7'b0000111;
  localparam opc_t OPC_OPIMM   = 7'b0010011;
  localparam opc_t OPC_OPIMM32 = 7'b0011011;
  localparam opc_t OPC_STORE   = 7'b0100011;
  localparam opc_t OPC_STOREFP = 7'b0100111;
  localparam opc_t OPC_OP      = 7'b0110011;
  localparam opc_t OPC_LUI     = 7'b0110111;
  localparam opc_t OPC_OP32    = 7'b0111011;
  localparam opc_t OPC_BRANCH  = 7'b1100011;
  localparam opc_t OPC_JALR    = 7'b1100111;
  localparam opc_t OPC_JAL     = 7'b1101111;
  localparam word_t BREAK_WORD = 32'h0010_0073;

  localparam ridx_t R_ZERO = 5'd0;
  localparam ridx_t R_RA   = 5'd1;
  localparam ridx_t R_SP   = 5'd2;

  typedef struct packed {
    logic  ill;
    word_t word;
  } xpand_t;

  function automatic word_t enc_i(logic [IMM_W-1:0] imm, ridx_t rs1, logic [2:0] f3,
                                  ridx_t rd, opc_t op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic word_t enc_s(logic [IMM_W-1:0] imm, ridx_t rs2, ridx_t rs1,
                                  logic [2:0] f3, opc_t op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic word_t enc_r(logic [6:0] f7, ridx_t rs2, ridx_t rs1, logic [2:0] f3,
                                  ridx_t rd, opc_t op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic word_t enc_u(logic [UIMM_W-1:0] imm, ridx_t rd, opc_t op);
    return {imm, rd, op};
  endfunction

  function automatic word_t enc_b(logic [BIMM_W-1:0] imm, ridx_t rs2, ridx_t rs1,
                                  logic [2:0] f3, opc_t op);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], op};
  endfunction

  function automatic word_t enc_j(logic [JIMM_W-1:0] imm, ridx_t rd, opc_t op);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, op};
  endfunction
endpackage

// File: rtl/rvc_q0_dec.sv
module rvc_q0_dec
  import rvc_pkg::*;
(
  input  logic [PARCEL_W-1:2] c_i,
  output xpand_t              res_o
);
  ridx_t rdp, rs1p;
  logic [IMM_W-1:0] imm_spn, imm_dw, imm_w;

  assign rdp     = {2'b01, c_i[4:2]};
  assign rs1p    = {2'b01, c_i[9:7]};
  assign imm_spn = {2'b00, c_i[10:7], c_i[12:11], c_i[5], c_i[6], 2'b00};
  assign imm_dw  = {4'b0, c_i[6:5], c_i[12:10], 3'b000};
  assign imm_w   = {5'b0, c_i[5], c_i[12:10], c_i[6], 2'b00};

  always_comb begin
    res_o = '0;
    unique case (c_i[15:13])
      3'b000: begin
        // zero immediate is reserved; covers the all-zero parcel
        if (imm_spn == '0) res_o.ill = 1'b1;
        else res_o.word = enc_i(imm_spn, R_SP, 3'b000, rdp, OPC_OPIMM);
      end
      3'b001: res_o.word = enc_i(imm_dw, rs1p, 3'b011, rdp, OPC_LOADFP);
      3'b010: res_o.word = enc_i(imm_w,  rs1p, 3'b010, rdp, OPC_LOAD);
      3'b011: res_o.word = enc_i(imm_dw, rs1p, 3'b011, rdp, OPC_LOAD);
      3'b100: res_o.ill  = 1'b1;
      3'b101: res_o.word = enc_s(imm_dw, rdp, rs1p, 3'b011, OPC_STOREFP);
      3'b110: res_o.word = enc_s(imm_w,  rdp, rs1p, 3'b010, OPC_STORE);
      default: res_o.word = enc_s(imm_dw, rdp, rs1p, 3'b011, OPC_STORE);
    endcase
  end
endmodule

// File: rtl/rvc_q1_dec.sv
module rvc_q1_dec
  import rvc_pkg::*;
(
  input  logic [PARCEL_W-1:2] c_i,
  output xpand_t              res_o
);
  ridx_t rd, rdp, rs2p;
  logic [IMM_W-1:0]  imm6, imm_sp, shamt_l, shamt_a;
  logic [UIMM_W-1:0] imm_up;
  logic [JIMM_W-1:0] imm_j;
  logic [BIMM_W-1:0] imm_br;

  assign rd      = c_i[11:7];
  assign rdp     = {2'b01, c_i[9:7]};
  assign rs2p    = {2'b01, c_i[4:2]};
  assign imm6    = {{6{c_i[12]}}, c_i[12], c_i[6:2]};
  assign imm_up  = {{14{c_i[12]}}, c_i[12], c_i[6:2]};
  assign imm_sp  = {{2{c_i[12]}}, c_i[12], c_i[4:3], c_i[5], c_i[2], c_i[6], 4'b0000};
  assign shamt_l = {6'b000000, c_i[12], c_i[6:2]};
  assign shamt_a = {6'b010000, c_i[12], c_i[6:2]};
  assign imm_j   = {{9{c_i[12]}}, c_i[12], c_i[8], c_i[10:9], c_i[6], c_i[7], c_i[2],
                    c_i[11], c_i[5:3], 1'b0};
  assign imm_br  = {{4{c_i[12]}}, c_i[12], c_i[6:5], c_i[2], c_i[11:10], c_i[4:3], 1'b0};

  always_comb begin
    res_o = '0;
    unique case (c_i[15:13])
      3'b000: res_o.word = enc_i(imm6, rd, 3'b000, rd, OPC_OPIMM);
      3'b001: begin
        if (rd == R_ZERO) res_o.ill = 1'b1;
        else res_o.word = enc_i(imm6, rd, 3'b000, rd, OPC_OPIMM32);
      end
      3'b010: res_o.word = enc_i(imm6, R_ZERO, 3'b000, rd, OPC_OPIMM);
      3'b011: begin
        if (rd == R_SP) begin
          if (imm_sp == '0) res_o.ill = 1'b1;
          else res_o.word = enc_i(imm_sp, R_SP, 3'b000, R_SP, OPC_OPIMM);
        end else begin
          if (imm_up == '0) res_o.ill = 1'b1;
          else res_o.word = enc_u(imm_up, rd, OPC_LUI);
        end
      end
      3'b100: begin
        unique case (c_i[11:10])
          2'b00: res_o.word = enc_i(shamt_l, rdp, 3'b101, rdp, OPC_OPIMM);
          2'b01: res_o.word = enc_i(shamt_a, rdp, 3'b101, rdp, OPC_OPIMM);
          2'b10: res_o.word = enc_i(imm6,    rdp, 3'b111, rdp, OPC_OPIMM);
          default: begin
            unique case ({c_i[12], c_i[6:5]})
              3'b000: res_o.word = enc_r(7'b0100000, rs2p, rdp, 3'b000, rdp, OPC_OP);
              3'b001: res_o.word = enc_r(7'b0000000, rs2p, rdp, 3'b100, rdp, OPC_OP);
              3'b010: res_o.word = enc_r(7'b0000000, rs2p, rdp, 3'b110, rdp, OPC_OP);
              3'b011: res_o.word = enc_r(7'b0000000, rs2p, rdp, 3'b111, rdp, OPC_OP);
              3'b100: res_o.word = enc_r(7'b0100000, rs2p, rdp, 3'b000, rdp, OPC_OP32);
              3'b101: res_o.word = enc_r(7'b0000000, rs2p, rdp, 3'b000, rdp, OPC_OP32);
              default: res_o.ill = 1'b1;
            endcase
          end
        endcase
      end
      3'b101: res_o.word = enc_j(imm_j, R_ZERO, OPC_JAL);
      3'b110: res_o.word = enc_b(imm_br, R_ZERO, rdp, 3'b000, OPC_BRANCH);
      default: res_o.word = enc_b(imm_br, R_ZERO, rdp, 3'b001, OPC_BRANCH);
    endcase
  end
endmodule

// File: rtl/rvc_q2_dec.sv
module rvc_q2_dec
  import rvc_pkg::*;
(
  input  logic [PARCEL_W-1:2] c_i,
  output xpand_t              res_o
);
  ridx_t rd, rs2;
  logic [IMM_W-1:0] shamt, imm_lw, imm_ld, imm_sw, imm_sd;

  assign rd     = c_i[11:7];
  assign rs2    = c_i[6:2];
  assign shamt  = {6'b000000, c_i[12], c_i[6:2]};
  assign imm_lw = {4'b0, c_i[3:2], c_i[12], c_i[6:4], 2'b00};
  assign imm_ld = {3'b0, c_i[4:2], c_i[12], c_i[6:5], 3'b000};
  assign imm_sw = {4'b0, c_i[8:7], c_i[12:9], 2'b00};
  assign imm_sd = {3'b0, c_i[9:7], c_i[12:10], 3'b000};

  always_comb begin
    res_o = '0;
    unique case (c_i[15:13])
      3'b000: res_o.word = enc_i(shamt, rd, 3'b001, rd, OPC_OPIMM);
      3'b001: res_o.word = enc_i(imm_ld, R_SP, 3'b011, rd, OPC_LOADFP);
      3'b010: begin
        if (rd == R_ZERO) res_o.ill = 1'b1;
        else res_o.word = enc_i(imm_lw, R_SP, 3'b010, rd, OPC_LOAD);
      end
      3'b011: begin
        if (rd == R_ZERO) res_o.ill = 1'b1;
        else res_o.word = enc_i(imm_ld, R_SP, 3'b011, rd, OPC_LOAD);
      end
      3'b100: begin
        if (rs2 != R_ZERO) begin
          res_o.word = enc_r(7'b0, rs2, c_i[12] ? rd : R_ZERO, 3'b000, rd, OPC_OP);
        end else if (rd == R_ZERO) begin
          if (c_i[12]) res_o.word = BREAK_WORD;
          else res_o.ill = 1'b1;
        end else begin
          res_o.word = enc_i('0, rd, 3'b000, c_i[12] ? R_RA : R_ZERO, OPC_JALR);
        end
      end
      3'b101: res_o.word = enc_s(imm_sd, rs2, R_SP, 3'b011, OPC_STOREFP);
      3'b110: res_o.word = enc_s(imm_sw, rs2, R_SP, 3'b010, OPC_STORE);
      default: res_o.word = enc_s(imm_sd, rs2, R_SP, 3'b011, OPC_STORE);
    endcase
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [ILEN-1:0] instr_i,
  output logic            valid_o,
  output logic [ILEN-1:0] expanded_o,
  output logic            illegal_o,
  output logic [ILEN-1:0] tval_o
);
  localparam int unsigned NQ = 3;

  xpand_t q_res [NQ];
  xpand_t nxt;

  rvc_q0_dec u_q0 (.c_i(instr_i[PARCEL_W-1:2]), .res_o(q_res[0]));
  rvc_q1_dec u_q1 (.c_i(instr_i[PARCEL_W-1:2]), .res_o(q_res[1]));
  rvc_q2_dec u_q2 (.c_i(instr_i[PARCEL_W-1:2]), .res_o(q_res[2]));

  always_comb begin
    nxt = '{ill: 1'b0, word: instr_i};
    for (int q = 0; q < NQ; q++) begin
      if (instr_i[1:0] == 2'(q)) nxt = q_res[q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      illegal_o  <= 1'b0;
      expanded_o <= '0;
      tval_o     <= '0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i & nxt.ill;
      if (valid_i) begin
        expanded_o <= nxt.ill ? '0 : nxt.word;
        tval_o     <= nxt.ill ? {{(ILEN-PARCEL_W){1'b0}}, instr_i[PARCEL_W-1:0]} : '0;
      end
    end
  end
endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] instr_i,
  input logic        valid_o,
  input logic [31:0] expanded_o,
  input logic        illegal_o,
  input logic [31:0] tval_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r11_no_illegal_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !illegal_o);
  a_r1_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[1:0] == 2'b11) |=> (!illegal_o && expanded_o == $past(instr_i)));
  a_r3_sp_load_rd0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[1:0] == 2'b10 && instr_i[15:14] == 2'b01 && instr_i[11:7] == 5'd0)
    |=> illegal_o);
  a_r6_zero_parcel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15:0] == 16'h0000) |=> illegal_o);
  a_r8_illegal_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (expanded_o == 32'h0 && tval_o[31:16] == 16'h0));
  a_r8_legal_tval_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o) |-> tval_o == 32'h0);
  a_r9_tval_parcel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[1:0] != 2'b11) |=> (!illegal_o || tval_o[15:0] == $past(instr_i[15:0])));
endmodule

bind rvc_expander rvc_expander_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
  .valid_o(valid_o), .expanded_o(expanded_o), .illegal_o(illegal_o), .tval_o(tval_o)
);

// File: tb/rvc_expander_test.sv
`timescale 1ns/1ps
module rvc_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [31:0] word_in = '0;
  logic        valid_out, ill_out;
  logic [31:0] exp_out, tval_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic        p_valid = 1'b0;
  logic        p_ill = 1'b0;
  logic [31:0] p_word = '0;
  logic [31:0] p_tval = '0;
  string       p_tag = "R2";

  always #2 clk = ~clk;

  rvc_expander uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .instr_i(word_in),
    .valid_o(valid_out), .expanded_o(exp_out), .illegal_o(ill_out), .tval_o(tval_out)
  );

  function automatic int sx(int v, int bits);
    return (v ^ (1 << (bits - 1))) - (1 << (bits - 1));
  endfunction

  function automatic logic [31:0] ii(int imm, int rs1, int f3, int rd, int op);
    return ((32'(imm) & 32'hfff) << 20) | (32'(rs1) << 15) | (32'(f3) << 12)
         | (32'(rd) << 7) | 32'(op);
  endfunction

  function automatic logic [31:0] ss(int imm, int rs2, int rs1, int f3, int op);
    return (((32'(imm) >> 5) & 32'h7f) << 25) | (32'(rs2) << 20) | (32'(rs1) << 15)
         | (32'(f3) << 12) | ((32'(imm) & 32'h1f) << 7) | 32'(op);
  endfunction

  function automatic logic [31:0] rr(int f7, int rs2, int rs1, int f3, int rd, int op);
    return (32'(f7) << 25) | (32'(rs2) << 20) | (32'(rs1) << 15) | (32'(f3) << 12)
         | (32'(rd) << 7) | 32'(op);
  endfunction

  function automatic logic [31:0] bb(int imm, int rs1, int f3);
    logic [31:0] m = 32'(imm);
    return ({31'b0, m[12]} << 31) | (((m >> 5) & 32'h3f) << 25) | (32'(rs1) << 15)
         | (32'(f3) << 12) | (((m >> 1) & 32'hf) << 8) | ({31'b0, m[11]} << 7) | 32'h63;
  endfunction

  function automatic logic [31:0] jj(int imm);
    logic [31:0] m = 32'(imm);
    return ({31'b0, m[20]} << 31) | (((m >> 1) & 32'h3ff) << 21) | ({31'b0, m[11]} << 20)
         | (((m >> 12) & 32'hff) << 12) | 32'h6f;
  endfunction

  // behavioural reference: returns {illegal, expansion}
  function automatic logic [32:0] ref_xp(logic [31:0] w);
    int q   = int'(w[1:0]);
    int f   = int'(w[15:13]);
    int rd  = int'(w[11:7]);
    int r2  = int'(w[6:2]);
    int dp  = 8 + int'(w[4:2]);
    int s1  = 8 + int'(w[9:7]);
    int b12 = int'(w[12]);
    int s6  = sx(b12 * 32 + r2, 6);
    int im;
    logic bad = 1'b0;
    logic [31:0] o = '0;
    if (q == 3) return {1'b0, w};
    case (q * 8 + f)
      0: begin
        im = int'(w[10:7]) * 64 + int'(w[12:11]) * 16 + int'(w[5]) * 8 + int'(w[6]) * 4;
        if (im == 0) bad = 1'b1; else o = ii(im, 2, 0, dp, 'h13);
      end
      1: o = ii(int'(w[6:5]) * 64 + int'(w[12:10]) * 8, s1, 3, dp, 'h07);
      2: o = ii(int'(w[5]) * 64 + int'(w[12:10]) * 8 + int'(w[6]) * 4, s1, 2, dp, 'h03);
      3: o = ii(int'(w[6:5]) * 64 + int'(w[12:10]) * 8, s1, 3, dp, 'h03);
      4: bad = 1'b1;
      5: o = ss(int'(w[6:5]) * 64 + int'(w[12:10]) * 8, dp, s1, 3, 'h27);
      6: o = ss(int'(w[5]) * 64 + int'(w[12:10]) * 8 + int'(w[6]) * 4, dp, s1, 2, 'h23);
      7: o = ss(int'(w[6:5]) * 64 + int'(w[12:10]) * 8, dp, s1, 3, 'h23);
      8: o = ii(s6, rd, 0, rd, 'h13);
      9: if (rd == 0) bad = 1'b1; else o = ii(s6, rd, 0, rd, 'h1b);
      10: o = ii(s6, 0, 0, rd, 'h13);
      11: begin
        if (rd == 2) begin
          im = sx(b12 * 512 + int'(w[4:3]) * 128 + int'(w[5]) * 64 + int'(w[2]) * 32
                  + int'(w[6]) * 16, 10);
          if (im == 0) bad = 1'b1; else o = ii(im, 2, 0, 2, 'h13);
        end else begin
          if (s6 == 0) bad = 1'b1;
          else o = ((32'(s6) & 32'hfffff) << 12) | (32'(rd) << 7) | 32'h37;
        end
      end
      12: begin
        case (int'(w[11:10]))
          0: o = ii(b12 * 32 + r2, s1, 5, s1, 'h13);
          1: o = ii(1024 + b12 * 32 + r2, s1, 5, s1, 'h13);
          2: o = ii(s6, s1, 7, s1, 'h13);
          default: begin
            case (b12 * 4 + int'(w[6:5]))
              0: o = rr(32, dp, s1, 0, s1, 'h33);
              1: o = rr(0, dp, s1, 4, s1, 'h33);
              2: o = rr(0, dp, s1, 6, s1, 'h33);
              3: o = rr(0, dp, s1, 7, s1, 'h33);
              4: o = rr(32, dp, s1, 0, s1, 'h3b);
              5: o = rr(0, dp, s1, 0, s1, 'h3b);
              default: bad = 1'b1;
            endcase
          end
        endcase
      end
      13: o = jj(sx(b12 * 2048 + int'(w[8]) * 1024 + int'(w[10:9]) * 256 + int'(w[6]) * 128
                    + int'(w[7]) * 64 + int'(w[2]) * 32 + int'(w[11]) * 16
                    + int'(w[5:3]) * 2, 12));
      14, 15: o = bb(sx(b12 * 256 + int'(w[6:5]) * 64 + int'(w[2]) * 32 + int'(w[11:10]) * 8
                        + int'(w[4:3]) * 2, 9), s1, f - 6);
      16: o = ii(b12 * 32 + r2, rd, 1, rd, 'h13);
      17: o = ii(int'(w[4:2]) * 64 + b12 * 32 + int'(w[6:5]) * 8, 2, 3, rd, 'h07);
      18: if (rd == 0) bad = 1'b1;
          else o = ii(int'(w[3:2]) * 64 + b12 * 32 + int'(w[6:4]) * 4, 2, 2, rd, 'h03);
      19: if (rd == 0) bad = 1'b1;
          else o = ii(int'(w[4:2]) * 64 + b12 * 32 + int'(w[6:5]) * 8, 2, 3, rd, 'h03);
      20: begin
        if (r2 != 0) o = rr(0, r2, (b12 == 1) ? rd : 0, 0, rd, 'h33);
        else if (rd == 0) begin
          if (b12 == 1) o = 32'h00100073; else bad = 1'b1;
        end else o = ii(0, rd, 0, b12, 'h67);
      end
      21: o = ss(int'(w[9:7]) * 64 + int'(w[12:10]) * 8, r2, 2, 3, 'h27);
      22: o = ss(int'(w[8:7]) * 64 + int'(w[12:9]) * 4, r2, 2, 2, 'h23);
      default: o = ss(int'(w[9:7]) * 64 + int'(w[12:10]) * 8, r2, 2, 3, 'h23);
    endcase
    if (bad) o = '0;
    return {bad, o};
  endfunction

  task automatic compare();
    bit ok;
    if (p_valid)
      ok = valid_out && (ill_out == p_ill) && (exp_out == p_word) && (tval_out == p_tval);
    else
      ok = !valid_out && !ill_out;
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got v=%0b ill=%0b exp=%08h tval=%08h, want v=%0b ill=%0b exp=%08h tval=%08h",
               p_tag, valid_out, ill_out, exp_out, tval_out, p_valid, p_ill, p_word, p_tval);
    end
  endtask

  task automatic step(logic v, logic [31:0] w, string tag);
    logic [32:0] r;
    @(negedge clk);
    compare();
    valid_in = v;
    word_in  = w;
    r = ref_xp(w);
    p_valid = v;
    p_ill   = v & r[32];
    p_word  = r[31:0];
    p_tval  = r[32] ? {16'h0, w[15:0]} : 32'h0;
    p_tag   = v ? tag : "R11";
  endtask

  task automatic direct(logic [31:0] w, logic want_ill, logic [31:0] want_word, string tag);
    logic [32:0] r = ref_xp(w);
    n_vec++;
    if (r[32] != want_ill || r[31:0] != want_word) begin
      n_bad++;
      $display("FAIL %s model: got ill=%0b exp=%08h, want ill=%0b exp=%08h",
               tag, r[32], r[31:0], want_ill, want_word);
    end
    step(1'b1, w, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;  // R2 reset state
    if (valid_out !== 1'b0 || ill_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 reset: got v=%0b ill=%0b, want 0 0", valid_out, ill_out);
    end
    rst_n = 1'b1;
    step(1'b0, 32'h0, "R2");
    direct(32'h0000401A, 1'b1, 32'h0, "R3");
    direct(32'h0000601A, 1'b1, 32'h0, "R3");
    direct(32'h0000409A, 1'b0, 32'h08412083, "R4");
    direct(32'h00008002, 1'b1, 32'h0, "R5");
    direct(32'h00002001, 1'b1, 32'h0, "R5");
    direct(32'h00006101, 1'b1, 32'h0, "R6");
    direct(32'h00006081, 1'b1, 32'h0, "R6");
    direct(32'h00000000, 1'b1, 32'h0, "R6");
    direct(32'h00008000, 1'b1, 32'h0, "R7");
    direct(32'h00009C41, 1'b1, 32'h0, "R7");
    direct(32'h00009C61, 1'b1, 32'h0, "R7");
    direct(32'h00009002, 1'b0, 32'h00100073, "R10");
    direct(32'h00000001, 1'b0, 32'h00000013, "R10");
    direct(32'h00A00093, 1'b0, 32'h00A00093, "R1");
    direct(32'h8931401A, 1'b1, 32'h0, "R9");
    direct(32'hFFFF409A, 1'b0, 32'h08412083, "R9");
    direct(32'h1234409A, 1'b0, 32'h08412083, "R8");
    step(1'b0, 32'h0000401A, "R11");
    step(1'b0, 32'h0, "R11");
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w = $urandom;
      logic v = ($urandom % 5) != 0;
      step(v, w, (w[1:0] == 2'b11) ? "R1" : "R10");
    end
    step(1'b0, 32'h0, "R2");
    step(1'b0, 32'h0, "R2");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: got no completion, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule